// File: doc/BRIEF.md
# Square-Tone Period Sweep Unit

This block moves the period of a square-wave tone channel up or down automatically at a slow, externally timed rate. On a trigger pulse it captures the channel's current 11-bit period into a private shadow copy, restarts its sweep timer and decides whether sweeping is active at all. Each time the sweep timer runs out, it derives a new period from the shadow copy by adding or subtracting a right-shifted copy of itself. It hands the new value back to the channel through a one-cycle write strobe, or it stops the channel through a one-cycle disable pulse when the result no longer fits in 11 bits.

The sweep timer advances only on a one-cycle `tick_i` pulse, which is expected at a rate of about 128 Hz. The sweep controls (`pace_i`, `dir_sub_i`, `shift_i`) are read live on every cycle. The channel period input is read only at trigger time.

Control is a five-state machine:

- `S_OFF`: sweep inactive. Ticks are ignored and no outputs are produced.
- `S_WAIT`: sweep active, counting ticks.
- `S_TCHK`: overflow check made right after a trigger.
- `S_CALC`: the committed calculation after the timer expires.
- `S_RECHK`: overflow-only recheck on the freshly written value.

Transitions:

- Any state goes to `S_TCHK` on a trigger with a non-zero shift.
- Any state goes to `S_WAIT` on a trigger with shift zero and pace non-zero.
- Any state goes to `S_OFF` on a trigger with pace and shift both zero.
- `S_WAIT` goes to `S_CALC` when the timer expires and pace is non-zero.
- `S_CALC` goes to `S_RECHK` when the value is written back, and to `S_WAIT` when shift is zero and there is no overflow.
- `S_TCHK` and `S_RECHK` go to `S_WAIT`.
- Any active state goes to `S_OFF` on an overflow or on a forbidden direction change.

Top module: `sq_sweep`

## Requirements
- R1: A trigger (`trig_i` high at a clock edge) copies `period_i` into the shadow period and reloads the sweep timer from `pace_i`; a trigger takes priority over every other event in the same cycle.
- R2: After a trigger with `pace_i` and `shift_i` both zero the unit is inactive: ticks cause no write strobe and no disable pulse until the next trigger.
- R3: After a trigger with a non-zero `shift_i`, one period calculation is made at once; if it overflows, `kill_o` is high for exactly one cycle, visible after the second clock edge counted from the trigger edge, and no write strobe follows.
- R4: A calculation forms a 12-bit result: the shadow period plus the shadow period shifted right by `shift_i`, or that shifted value subtracted instead when `dir_sub_i` is 1 (1 = subtract, 0 = add); a result above 2047 (bit 11 set) is an overflow.
- R5: An overflow pulses `kill_o` for one cycle and leaves the unit inactive until the next trigger.
- R6: When a tick exhausts the sweep timer and `pace_i` is non-zero, a calculation is made. If there is no overflow and `shift_i` is non-zero, the result goes into the shadow period and `wb_valid_o` is high for one cycle with `wb_period_o` carrying it. The strobe, or the overflow pulse, is visible after the second clock edge counted from the edge that sampled the expiring tick. The timer reloads from `pace_i` on expiry.
- R7: After each write-back a second calculation is made from the new shadow value for the overflow check only; an overflow there pulses `kill_o` one cycle after the write strobe, and its result is never written back.
- R8: A `pace_i` of 0 loads the sweep timer with 8, so a pace raised from 0 to a non-zero value after a trigger first takes effect on the 8th tick.
- R9: If `dir_sub_i` goes from 1 to 0 after at least one subtract-mode calculation since the last trigger, `kill_o` pulses for one cycle, visible after the first clock edge that samples the 0, and the unit goes inactive.
- R10: Changes on `period_i` after a trigger do not alter the shadow period; the next write-back is derived from the value captured at the trigger.
- R11: During and after reset, `wb_valid_o` and `kill_o` are low and the unit is inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Channel trigger pulse |
| tick_i | input | 1 | Sweep-rate tick, one cycle wide |
| period_i | input | 11 | Channel period, captured on trigger |
| pace_i | input | 3 | Ticks per sweep step (0 behaves as 8 for the timer, but disables stepping) |
| dir_sub_i | input | 1 | 1 = subtract, 0 = add |
| shift_i | input | 3 | Right-shift amount for the step size |
| wb_valid_o | output | 1 | One-cycle strobe: write `wb_period_o` into the channel period |
| wb_period_o | output | 11 | New channel period |
| kill_o | output | 1 | One-cycle pulse: disable the channel |

## Verification
The hardest case to reach is the non-committed recheck overflow. That takes a first result that still fits in 11 bits while its successor does not, and it only appears when shift, direction and starting period line up. The bench reaches it by sweeping every shift and both directions across a set of starting periods near the top of the range, including 0x555 and 0x6AB, and running several sweep steps after each trigger. The bench keeps its own arithmetic model of the shadow value and predicts both pulses. The rule that kills the channel on a direction change, and the effect of a pace 0 reload, are reached by directed sequences that alter the live controls between triggers.

// File: rtl/sq_sweep_pkg.sv
package sq_sweep_pkg;

    typedef enum logic [2:0] {
        S_OFF   = 3'd0,
        S_WAIT  = 3'd1,
        S_TCHK  = 3'd2,
        S_CALC  = 3'd3,
        S_RECHK = 3'd4
    } sweep_state_t;

endpackage

// File: rtl/sq_sweep_calc.sv
module sq_sweep_calc #(
    parameter int PW = 11,
    parameter int SW = 3
) (
    input  logic [PW-1:0] shadow_i,
    input  logic [SW-1:0] shift_i,
    input  logic          sub_i,
    output logic [PW:0]   sum_o,
    output logic          ovf_o
);

    logic [PW:0] base;
    logic [PW:0] delta;

    always_comb begin
        base  = {1'b0, shadow_i};
        delta = base >> shift_i;
        if (sub_i) begin
            sum_o = base - delta;
        end else begin
            sum_o = base + delta;
        end
        // carry out of the top period bit marks a value above the maximum
        ovf_o = sum_o[PW];
    end

endmodule

// File: rtl/sq_sweep_timer.sv
module sq_sweep_timer #(
    parameter int PACE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [PACE_W-1:0] pace_i,
    output logic              expire_o
);

    localparam int TW = PACE_W + 1;
    localparam logic [TW-1:0] FULL = TW'(2 ** PACE_W);

    logic [TW-1:0] cnt_q;
    logic [TW-1:0] reload;

    always_comb begin
        if (pace_i == '0) begin
            reload = FULL;
        end else begin
            reload = {1'b0, pace_i};
        end
        expire_o = step_i && (cnt_q == TW'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= FULL;
        end else if (load_i) begin
            cnt_q <= reload;
        end else if (step_i) begin
            if (cnt_q == TW'(1)) begin
                cnt_q <= reload;
            end else begin
                cnt_q <= cnt_q - TW'(1);
            end
        end
    end

    p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) && (cnt_q <= FULL));

endmodule

// File: rtl/sq_sweep_guard.sv
module sq_sweep_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic mark_i,
    input  logic dir_sub_i,
    output logic dir_kill_o
);

    logic used_q;
    logic dir_q;

    assign dir_kill_o = used_q && dir_q && !dir_sub_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= 1'b0;
            dir_q  <= 1'b0;
        end else begin
            dir_q <= dir_sub_i;
            if (clear_i) begin
                used_q <= 1'b0;
            end else if (mark_i) begin
                used_q <= 1'b1;
            end
        end
    end

    p_used_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !used_q);

endmodule

// File: rtl/sq_sweep.sv
module sq_sweep
    import sq_sweep_pkg::*;
#(
    parameter int PW     = 11,
    parameter int SW     = 3,
    parameter int PACE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              tick_i,
    input  logic [PW-1:0]     period_i,
    input  logic [PACE_W-1:0] pace_i,
    input  logic              dir_sub_i,
    input  logic [SW-1:0]     shift_i,
    output logic              wb_valid_o,
    output logic [PW-1:0]     wb_period_o,
    output logic              kill_o
);

    sweep_state_t state_q, state_d;

    logic [PW-1:0] shadow_q;
    logic [PW:0]   sum;
    logic          ovf;
    logic          expire;
    logic          dir_kill;
    logic          in_calc;
    logic          step;
    logic          shift_nz;
    logic          pace_nz;

    assign shift_nz = (shift_i != '0);
    assign pace_nz  = (pace_i != '0);
    assign in_calc  = (state_q == S_TCHK) || (state_q == S_CALC) || (state_q == S_RECHK);
    assign step     = tick_i && !trig_i && (state_q == S_WAIT);

    sq_sweep_calc #(.PW(PW), .SW(SW)) u_calc (
        .shadow_i (shadow_q),
        .shift_i  (shift_i),
        .sub_i    (dir_sub_i),
        .sum_o    (sum),
        .ovf_o    (ovf)
    );

    sq_sweep_timer #(.PACE_W(PACE_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (trig_i),
        .step_i   (step),
        .pace_i   (pace_i),
        .expire_o (expire)
    );

    sq_sweep_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (trig_i),
        .mark_i     (in_calc && dir_sub_i),
        .dir_sub_i  (dir_sub_i),
        .dir_kill_o (dir_kill)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (trig_i) begin
            if (shift_nz) begin
                state_d = S_TCHK;
            end else if (pace_nz) begin
                state_d = S_WAIT;
            end else begin
                state_d = S_OFF;
            end
        end else begin
            unique case (state_q)
                S_OFF: begin
                    state_d = S_OFF;
                end
                S_WAIT: begin
                    if (dir_kill) begin
                        state_d = S_OFF;
                    end else if (expire && pace_nz) begin
                        state_d = S_CALC;
                    end
                end
                S_TCHK: begin
                    state_d = (ovf || dir_kill) ? S_OFF : S_WAIT;
                end
                S_CALC: begin
                    if (ovf || dir_kill) begin
                        state_d = S_OFF;
                    end else if (shift_nz) begin
                        state_d = S_RECHK;
                    end else begin
                        state_d = S_WAIT;
                    end
                end
                S_RECHK: begin
                    state_d = (ovf || dir_kill) ? S_OFF : S_WAIT;
                end
            endcase
        end
    end

    // state register and shadow period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_OFF;
            shadow_q <= '0;
        end else begin
            state_q <= state_d;
            if (trig_i) begin
                shadow_q <= period_i;
            end else if ((state_q == S_CALC) && !ovf && !dir_kill && shift_nz) begin
                shadow_q <= sum[PW-1:0];
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid_o  <= 1'b0;
            wb_period_o <= '0;
            kill_o      <= 1'b0;
        end else begin
            wb_valid_o <= 1'b0;
            kill_o     <= 1'b0;
            if (!trig_i) begin
                if ((state_q == S_CALC) && !ovf && !dir_kill && shift_nz) begin
                    wb_valid_o  <= 1'b1;
                    wb_period_o <= sum[PW-1:0];
                end
                if ((in_calc && ovf) || ((state_q != S_OFF) && dir_kill)) begin
                    kill_o <= 1'b1;
                end
            end
        end
    end

    p_wb_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |=> !wb_valid_o);

    p_wb_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> ($past(shift_i) != '0));

    p_trig_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> (!wb_valid_o && !kill_o));

    p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_OFF) && !trig_i) |=> (!wb_valid_o && !kill_o));

    p_kill_idles_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_o && !$past(trig_i) && !trig_i) |-> (state_q == S_OFF));

    p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid_o && kill_o));

endmodule

// File: tb/sim_sq_sweep.sv
`timescale 1ns/100ps
module sim_sq_sweep;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        trig, tick, dir;
    logic [10:0] period;
    logic [2:0]  pace, shift;
    logic        wb_valid, kill;
    logic [10:0] wb_period;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_shadow, m_timer;
    bit m_en, m_alive;

    always #2.5 clk = ~clk;

    sq_sweep u0 (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .tick_i(tick),
        .period_i(period), .pace_i(pace), .dir_sub_i(dir), .shift_i(shift),
        .wb_valid_o(wb_valid), .wb_period_o(wb_period), .kill_o(kill)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int calc(input int p);
        int d;
        d = p >> shift;
        return dir ? (p - d) : (p + d);
    endfunction

    task automatic do_trig(input int p, input int pc, input bit d, input int s);
        int v;
        bit ek;
        @(negedge clk);
        period = 11'(p); pace = 3'(pc); dir = d; shift = 3'(s); trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        m_shadow = p;
        m_timer  = (pc == 0) ? 8 : pc;
        m_en     = (pc != 0) || (s != 0);
        m_alive  = 1'b1;
        ek = 1'b0;
        if (s != 0) begin
            v = calc(p);
            if (v > 2047) ek = 1'b1;
        end
        @(negedge clk);
        check(kill == ek, "R3", kill, ek);
        check(wb_valid == 1'b0, "R3", wb_valid, 0);
        if (ek) m_alive = 1'b0;
    endtask

    task automatic do_tick();
        int v, v2, ewp;
        bit ew, ek1, ek2;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        ew = 0; ek1 = 0; ek2 = 0; ewp = 0;
        if (m_alive && m_en) begin
            m_timer--;
            if (m_timer == 0) begin
                m_timer = (pace == 0) ? 8 : int'(pace);
                if (pace != 0) begin
                    v = calc(m_shadow);
                    if (v > 2047) begin
                        ek1 = 1;
                    end else if (shift != 0) begin
                        ew = 1; ewp = v; m_shadow = v;
                        v2 = calc(m_shadow);
                        if (v2 > 2047) ek2 = 1;
                    end
                end
            end
        end
        @(negedge clk);
        check(wb_valid == ew, "R6", wb_valid, ew);
        if (ew) check(int'(wb_period) == ewp, "R4", wb_period, ewp);
        check(kill == ek1, "R5", kill, ek1);
        @(negedge clk);
        check(kill == ek2, "R7", kill, ek2);
        check(wb_valid == 1'b0, "R7", wb_valid, 0);
        if (ek1 || ek2) m_alive = 1'b0;
    endtask

    initial begin
        #150000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int plist [6];
        int pcl [3];
        plist = '{0, 1, 'h400, 'h555, 'h7FF, 'h6AB};
        pcl   = '{1, 3, 0};
        rst_n = 0; trig = 0; tick = 0; dir = 0; period = 0; pace = 0; shift = 0;
        repeat (3) @(negedge clk);
        check(wb_valid == 0 && kill == 0, "R11", {wb_valid, kill}, 0);
        rst_n = 1;
        repeat (2) do_tick();   // R11: inactive after reset, ticks do nothing

        // near-exhaustive sweep: every shift, both directions, several periods and paces
        foreach (pcl[i]) begin
            for (int s = 0; s < 8; s++) begin
                for (int d = 0; d < 2; d++) begin
                    foreach (plist[k]) begin
                        do_trig(plist[k], pcl[i], d[0], s);
                        for (int t = 0; t < 4; t++) do_tick();
                    end
                end
            end
        end

        // R2: pace and shift zero leaves the unit idle
        do_trig('h7FF, 0, 0, 0);
        for (int t = 0; t < 9; t++) do_tick();

        // R10: period changes after trigger are not captured
        do_trig('h100, 1, 0, 1);
        period = 11'h7F0;
        do_tick();
        check(m_shadow == 'h180, "R10", m_shadow, 'h180);

        // R8: pace 0 loads 8; raising pace afterwards first acts on tick 8
        do_trig('h100, 0, 0, 1);
        pace = 3'd1;
        for (int t = 0; t < 8; t++) do_tick();
        check(m_shadow == 'h180, "R8", m_shadow, 'h180);

        // R9: direction cleared after a subtract calculation kills the channel
        do_trig('h400, 1, 1, 1);
        do_tick();
        @(negedge clk);
        dir = 1'b0;
        @(negedge clk);
        check(kill == 1'b1, "R9", kill, 1);
        @(negedge clk);
        check(kill == 1'b0, "R9", kill, 0);
        m_alive = 1'b0;
        do_tick();   // R5: inactive afterwards

        // R9: no subtract calculation yet, so clearing direction is harmless
        do_trig('h400, 2, 0, 0);
        @(negedge clk); dir = 1'b1;
        @(negedge clk); dir = 1'b0;
        @(negedge clk);
        check(kill == 1'b0, "R9", kill, 0);
        @(negedge clk);
        check(kill == 1'b0, "R9", kill, 0);

        // R1: trigger while running restarts from the new period
        do_trig('h200, 1, 0, 2);
        do_tick();
        check(m_shadow == 'h280, "R1", m_shadow, 'h280);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule